// File: doc/BRIEF.md
# Three-State Sequence Controller

This block sequences a small datapath through three steps: an idle step that waits for a go request, a busy step that runs until two status conditions hold together, and a one-cycle finish step that returns to idle. Each step has its own strobe output, and exactly one strobe is high in every cycle after clear.

A build-time parameter selects how the state is stored. With `ONE_HOT = 0` the state is a two-bit code decoded into the strobes. The codes are idle = 00, busy = 01 and finish = 11; code 10 is never entered. With `ONE_HOT = 1` each step has its own flop. The idle flop holds the complement of the idle condition, so clearing every flop to zero lands in idle without a preset. Both variants give identical strobe sequences for the same input stream.

Top module: `seq_ctrl`

## Requirements
- R1: Clear is synchronous and active high. At a clock edge with `clr` = 1, the controller enters idle (`st_idle` = 1, `st_busy` = 0, `st_fin` = 0), whatever the state and the other inputs are.
- R2: In idle with `go` = 0, the controller stays in idle at the next edge.
- R3: In idle with `go` = 1, the controller moves to busy at the next edge.
- R4: In busy, the controller stays in busy unless `cond_a` and `cond_b` are both 1.
- R5: In busy with `cond_a` = 1 and `cond_b` = 1, the controller moves to finish at the next edge.
- R6: From finish, the controller returns to idle at the next edge, whatever `go`, `cond_a` and `cond_b` are.
- R7: In every cycle after the first clear, exactly one of `st_idle`, `st_busy` and `st_fin` is 1.
- R8: The binary variant (`ONE_HOT` = 0) and the one-flop-per-state variant (`ONE_HOT` = 1) produce the same strobe values in every cycle when given the same clear and input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear, active high |
| go | input | 1 | Request to leave idle |
| cond_a | input | 1 | First status condition from the datapath |
| cond_b | input | 1 | Second status condition from the datapath |
| st_idle | output | 1 | High while in the idle step |
| st_busy | output | 1 | High while in the busy step |
| st_fin | output | 1 | High while in the finish step |

## Verification
A clear and a state transition can fall in the same cycle. For example, `clr` may rise together with `go` in idle, or together with both conditions in busy, and then the clear must win. The bench provokes this two ways. It sweeps every state against all sixteen combinations of `clr`, `go`, `cond_a` and `cond_b`, and it runs a long random stream in which clear arrives at arbitrary points. Each outcome is judged against a state model computed in the bench, for both encodings side by side.

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic go,
  input  logic cond_a,
  input  logic cond_b,
  output logic st_idle,
  output logic st_busy,
  output logic st_fin
);

  logic both;
  assign both = cond_a & cond_b;

  generate
    if (ONE_HOT) begin : g_onehot
      // idle flop holds the complement so an all-zero clear means idle
      logic idle_n, busy_q, fin_q;

      always_ff @(posedge clk) begin
        if (clr) begin
          idle_n <= 1'b0;
          busy_q <= 1'b0;
          fin_q  <= 1'b0;
        end else begin
          idle_n <= ~(fin_q | (~go & ~idle_n));
          busy_q <= (go & ~idle_n) | (~both & busy_q);
          fin_q  <= both & busy_q;
        end
      end

      assign st_idle = ~idle_n;
      assign st_busy = busy_q;
      assign st_fin  = fin_q;
    end else begin : g_binary
      logic [1:0] code;

      assign st_idle = (code == 2'b00);
      assign st_busy = (code == 2'b01);
      assign st_fin  = (code == 2'b11);

      // code 10 decodes to no state, so both next bits are 0 and it falls to idle
      always_ff @(posedge clk) begin
        if (clr) code <= 2'b00;
        else     code <= {st_busy & both, (st_idle & go) | st_busy};
      end
    end
  endgenerate

endmodule

module seq_ctrl_chk (
  input logic clk,
  input logic clr,
  input logic go,
  input logic cond_a,
  input logic cond_b,
  input logic st_idle,
  input logic st_busy,
  input logic st_fin
);

  logic seen = 1'b0;
  always_ff @(posedge clk) if (clr) seen <= 1'b1;

  p_clear_idle_r1: assert property (@(posedge clk)
    clr |=> (st_idle && !st_busy && !st_fin));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (clr || !seen)
    (st_idle && !go) |=> st_idle);

  p_idle_go_r3: assert property (@(posedge clk) disable iff (clr || !seen)
    (st_idle && go) |=> st_busy);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (clr || !seen)
    (st_busy && !(cond_a && cond_b)) |=> st_busy);

  p_busy_done_r5: assert property (@(posedge clk) disable iff (clr || !seen)
    (st_busy && cond_a && cond_b) |=> st_fin);

  p_fin_back_r6: assert property (@(posedge clk) disable iff (clr || !seen)
    st_fin |=> st_idle);

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!seen)
    $countones({st_idle, st_busy, st_fin}) == 1);

endmodule

bind seq_ctrl seq_ctrl_chk chk (
  .clk(clk), .clr(clr), .go(go), .cond_a(cond_a), .cond_b(cond_b),
  .st_idle(st_idle), .st_busy(st_busy), .st_fin(st_fin)
);

// File: tb/seq_ctrl_test.sv
module seq_ctrl_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic clr = 1'b1, go = 1'b0, cond_a = 1'b0, cond_b = 1'b0;
  logic b_idle, b_busy, b_fin, h_idle, h_busy, h_fin;
  int total = 0, bad = 0;
  int model = 0;
  bit finished = 1'b0;

  seq_ctrl #(.ONE_HOT(1'b0)) uut (
    .clk(clk), .clr(clr), .go(go), .cond_a(cond_a), .cond_b(cond_b),
    .st_idle(b_idle), .st_busy(b_busy), .st_fin(b_fin));

  seq_ctrl #(.ONE_HOT(1'b1)) uut_oh (
    .clk(clk), .clr(clr), .go(go), .cond_a(cond_a), .cond_b(cond_b),
    .st_idle(h_idle), .st_busy(h_busy), .st_fin(h_fin));

  function automatic string tag_of(int m, logic c, logic g, logic a, logic b);
    if (c) return "R1";
    if (m == 0) return g ? "R3" : "R2";
    if (m == 1) return (a & b) ? "R5" : "R4";
    return "R6";
  endfunction

  function automatic int next_of(int m, logic c, logic g, logic a, logic b);
    if (c) return 0;
    if (m == 0) return g ? 1 : 0;
    if (m == 1) return (a & b) ? 2 : 1;
    return 0;
  endfunction

  task automatic check(string tag);
    logic [2:0] exp, bv, hv;
    exp = 3'b001 << model;
    bv = {b_fin, b_busy, b_idle};
    hv = {h_fin, h_busy, h_idle};
    total++;
    if (bv !== exp) begin bad++; $display("FAIL %s binary: got %b expected %b", tag, bv, exp); end
    total++;
    if (hv !== exp) begin bad++; $display("FAIL %s onehot: got %b expected %b", tag, hv, exp); end
    total++;
    if ($countones(bv) != 1 || $countones(hv) != 1) begin
      bad++; $display("FAIL R7 strobes: got %b/%b expected one-hot", bv, hv);
    end
    total++;
    if (bv !== hv) begin bad++; $display("FAIL R8 encodings differ: got %b vs %b expected equal", bv, hv); end
  endtask

  task automatic step(logic c, logic g, logic a, logic b);
    string tag;
    int nxt;
    clr = c; go = g; cond_a = a; cond_b = b;
    tag = tag_of(model, c, g, a, b);
    nxt = next_of(model, c, g, a, b);
    @(posedge clk);
    @(negedge clk);
    model = nxt;
    check(tag);
  endtask

  initial begin
    step(1'b1, 1'b1, 1'b1, 1'b1);   // R1 first clear with all other inputs high
    for (int st = 0; st < 3; st++) begin
      for (int in = 0; in < 16; in++) begin
        step(1'b1, 1'b0, 1'b0, 1'b0);
        if (st >= 1) step(1'b0, 1'b1, 1'b0, 1'b0);
        if (st == 2) step(1'b0, 1'b0, 1'b1, 1'b1);
        step(in[3], in[2], in[1], in[0]);   // R1..R6 sweep: every state, every input
      end
    end
    for (int k = 0; k < 4000; k++) begin
      logic [4:0] r;
      r = 5'($urandom);
      step(($urandom % 32) == 0, r[0], r[1] | r[3], r[2] | r[4]);  // R8 random stream
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule